// File: doc/BRIEF.md
# Overlay Command Issue Sequencer

This block sits on the host side of a memory device that accepts its commands through a window of registers. A single command request carries a command code, a wide target address, an optional length, an optional data word and a flag that says whether the data word is present. The block turns that request into a fixed series of register writes on a narrow bus. Each write goes to a register offset that is added to a programmable window base. The address and the length are each split into a low and a high half that fit the bus width.

The last write starts the device working. The block then reads the device status register over and over until the ready bit is set. It then returns one response with the error bits taken from that final read. The device clears those bits when they are read, so the response is the only place they remain.

A bounded number of polls guards against a device that never becomes ready. When the bound is reached, the command is ended with a timeout flag. Only one command is in flight at a time. Every bus access is held until the bus acknowledges it.

Top module: `ovl_cmd_seq`

## Requirements
- R1: After reset, req_ready is 1, and bus_req and rsp_valid are both 0.
- R2: An accepted request first writes the zero-extended command code to base+0x80. It then writes address bits [BUS_W-1:0] to base+0x88, and then the remaining upper address bits, zero-extended, to base+0x8A.
- R3: The length low half is written to base+0x90 and then the length high half to base+0x92. These two writes happen right after the address writes, and only when the whole length is nonzero. A length with only upper bits set still produces both writes.
- R4: The data word is written to base+0x84 only when req_data_vld was 1 at acceptance. It comes after any length writes.
- R5: The last write of every command writes 0x0001 to base+0xC0.
- R6: An access keeps bus_req, bus_we, bus_addr and bus_wdata unchanged until the clock edge at which bus_ack is 1. The next access follows only after that edge.
- R7: After the start write, the block issues reads (bus_we=0) at base+0x cc until a read returns bit 7 set. Then rsp_valid pulses for exactly one cycle, and no further bus access happens.
- R8: With the response, rsp_err equals the final status value ANDed with 0x133A, and rsp_fail is 1 exactly when that result is nonzero.
- R9: req_ready is 0 from the acceptance edge until the response. A request presented in that time is ignored and starts no bus writes.
- R10: If MAX_POLLS status reads all return bit 7 clear, the command ends after the last of them with rsp_timeout=1. rsp_err is still taken from that last read. A ready result on exactly the last allowed read gives rsp_timeout=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_addr | input | BADDR_W | Register window base, captured at acceptance |
| req_valid | input | 1 | Command request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_code | input | CODE_W | Command code |
| req_addr | input | ADDR_W | Target address |
| req_len | input | LEN_W | Length; zero skips the length writes |
| req_data | input | BUS_W | Data word |
| req_data_vld | input | 1 | Data word is present |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | BUS_W | Error bits of the final status read |
| rsp_fail | output | 1 | Any error bit set |
| rsp_timeout | output | 1 | Poll bound reached without ready |
| bus_req | output | 1 | Bus access pending |
| bus_we | output | 1 | 1 for write, 0 for status read |
| bus_addr | output | BADDR_W | Access address |
| bus_wdata | output | BUS_W | Write data |
| bus_ack | input | 1 | Access completed |
| bus_rdata | input | BUS_W | Read data, valid with bus_ack |

## Verification
The bench builds the block with a 16-bit bus, a 32-bit address and length, and a 24-bit window base. Each address and length therefore has real upper halves to split. MAX_POLLS is lowered to 4, so the timeout path can be reached in a few cycles. The same setting makes the boundary between ready on the fourth read and giving up after it reachable. A slave model with an adjustable acknowledge latency exercises both back-to-back accesses and accesses that are held for several cycles.

// File: rtl/ovl_cmd_pkg.sv
package ovl_cmd_pkg;

  typedef enum logic [2:0] {
    ST_CODE, ST_ALO, ST_AHI, ST_LLO, ST_LHI, ST_DATA, ST_EXEC, ST_POLL
  } step_e;

  localparam int OFF_W = 8;

  // successor of a step; optional steps are skipped by the two flags
  function automatic step_e step_after(step_e s, logic has_len, logic has_dat);
    step_e n;
    case (s)
      ST_CODE: n = ST_ALO;
      ST_ALO:  n = ST_AHI;
      ST_AHI:  n = has_len ? ST_LLO : (has_dat ? ST_DATA : ST_EXEC);
      ST_LLO:  n = ST_LHI;
      ST_LHI:  n = has_dat ? ST_DATA : ST_EXEC;
      ST_DATA: n = ST_EXEC;
      default: n = ST_POLL;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/ovl_step_map.sv
module ovl_step_map
  import ovl_cmd_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int CODE_W = 8,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 32
) (
  input  step_e              step,
  input  logic [CODE_W-1:0]  code,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [LEN_W-1:0]   len,
  input  logic [BUS_W-1:0]   data,
  output logic [OFF_W-1:0]   off,
  output logic [BUS_W-1:0]   wdata
);
  logic [ADDR_W-1:0] addr_up;
  logic [LEN_W-1:0]  len_up;

  assign addr_up = addr >> BUS_W;
  assign len_up  = len >> BUS_W;

  always_comb begin
    off   = 8'hCC;
    wdata = '0;
    case (step)
      ST_CODE: begin off = 8'h80; wdata = BUS_W'(code); end
      ST_ALO:  begin off = 8'h88; wdata = addr[BUS_W-1:0]; end
      ST_AHI:  begin off = 8'h8A; wdata = addr_up[BUS_W-1:0]; end
      ST_LLO:  begin off = 8'h90; wdata = len[BUS_W-1:0]; end
      ST_LHI:  begin off = 8'h92; wdata = len_up[BUS_W-1:0]; end
      ST_DATA: begin off = 8'h84; wdata = data; end
      ST_EXEC: begin off = 8'hC0; wdata = BUS_W'(1); end
      default: begin off = 8'hCC; wdata = '0; end
    endcase
  end
endmodule

// File: rtl/ovl_poll_ctr.sv
module ovl_poll_ctr #(
  parameter int MAX_POLLS = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic tick,
  output logic last
);
  localparam int CNT_W = $clog2(MAX_POLLS + 1);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (tick)    cnt <= cnt + 1'b1;
  end

  assign last = (cnt == CNT_W'(MAX_POLLS - 1));

  // R10
  poll_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(MAX_POLLS));
endmodule

// File: rtl/ovl_cmd_seq.sv
module ovl_cmd_seq
  import ovl_cmd_pkg::*;
#(
  parameter int BUS_W     = 16,
  parameter int CODE_W    = 8,
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 32,
  parameter int BADDR_W   = 24,
  parameter int MAX_POLLS = 1000,
  parameter int RDY_BIT   = 7,
  parameter logic [BUS_W-1:0] ERR_MASK = BUS_W'(16'h133A)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [BADDR_W-1:0] base_addr,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [CODE_W-1:0]  req_code,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [LEN_W-1:0]   req_len,
  input  logic [BUS_W-1:0]   req_data,
  input  logic               req_data_vld,
  output logic               rsp_valid,
  output logic [BUS_W-1:0]   rsp_err,
  output logic               rsp_fail,
  output logic               rsp_timeout,
  output logic               bus_req,
  output logic               bus_we,
  output logic [BADDR_W-1:0] bus_addr,
  output logic [BUS_W-1:0]   bus_wdata,
  input  logic               bus_ack,
  input  logic [BUS_W-1:0]   bus_rdata
);
  logic               busy;
  step_e              step_q;
  logic [BADDR_W-1:0] base_q;
  logic [CODE_W-1:0]  code_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [LEN_W-1:0]   len_q;
  logic [BUS_W-1:0]   data_q;
  logic               dvld_q;
  logic [OFF_W-1:0]   off;
  logic               accept, poll_done, poll_last, dev_rdy;
  logic [BUS_W-1:0]   err_bits;

  assign req_ready = !busy;
  assign accept    = req_valid && !busy;
  assign dev_rdy   = bus_rdata[RDY_BIT];
  assign err_bits  = bus_rdata & ERR_MASK;
  assign poll_done = busy && bus_ack && (step_q == ST_POLL);

  ovl_step_map #(.BUS_W(BUS_W), .CODE_W(CODE_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_map (
    .step(step_q), .code(code_q), .addr(addr_q), .len(len_q), .data(data_q),
    .off(off), .wdata(bus_wdata)
  );

  ovl_poll_ctr #(.MAX_POLLS(MAX_POLLS)) u_poll (
    .clk(clk), .rst(rst), .clear(accept), .tick(poll_done), .last(poll_last)
  );

  assign bus_we   = (step_q != ST_POLL);
  assign bus_addr = base_q + BADDR_W'(off);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      bus_req     <= 1'b0;
      step_q      <= ST_CODE;
      base_q      <= '0;
      code_q      <= '0;
      addr_q      <= '0;
      len_q       <= '0;
      data_q      <= '0;
      dvld_q      <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_err     <= '0;
      rsp_fail    <= 1'b0;
      rsp_timeout <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        bus_req <= 1'b1;
        step_q  <= ST_CODE;
        base_q  <= base_addr;
        code_q  <= req_code;
        addr_q  <= req_addr;
        len_q   <= req_len;
        data_q  <= req_data;
        dvld_q  <= req_data_vld;
      end else if (busy && bus_ack) begin
        if (step_q != ST_POLL) begin
          step_q <= step_after(step_q, |len_q, dvld_q);
        end else if (dev_rdy || poll_last) begin
          busy        <= 1'b0;
          bus_req     <= 1'b0;
          rsp_valid   <= 1'b1;
          rsp_err     <= err_bits;
          rsp_fail    <= |err_bits;
          rsp_timeout <= !dev_rdy;
        end
      end
    end
  end

  // R6
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)
                               && $stable(bus_wdata)));
  // R9
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> !req_ready);
  // R7
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  // R7
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(bus_req && !bus_we && bus_ack));
  // R7
  idle_after_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !bus_req);
endmodule

// File: tb/tb_ovl_cmd_seq.sv
module tb_ovl_cmd_seq;
  localparam int BUS_W = 16, CODE_W = 8, ADDR_W = 32, LEN_W = 32, BADDR_W = 24;
  localparam int MAXP = 4;

  logic clk = 0, rst = 1;
  logic [BADDR_W-1:0] base_addr = '0;
  logic req_valid = 0, req_ready;
  logic [CODE_W-1:0] req_code = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic [BUS_W-1:0]  req_data = '0;
  logic req_data_vld = 0;
  logic rsp_valid, rsp_fail, rsp_timeout;
  logic [BUS_W-1:0] rsp_err;
  logic bus_req, bus_we, bus_ack = 0;
  logic [BADDR_W-1:0] bus_addr;
  logic [BUS_W-1:0] bus_wdata, bus_rdata = '0;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  ovl_cmd_seq #(.BUS_W(BUS_W), .CODE_W(CODE_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
                .BADDR_W(BADDR_W), .MAX_POLLS(MAXP)) dut (.*);

  // slave model and access log
  int lat = 0, wcnt = 0, n_wr = 0, n_rd = 0, bad_rd = 0;
  logic [BADDR_W-1:0] log_a [0:15];
  logic [BUS_W-1:0]   log_d [0:15];
  logic [BUS_W-1:0]   stat [0:7];
  int n_stat = 1;

  initial begin
    forever begin
      @(negedge clk);
      bus_ack = 0;
      if (bus_req) begin
        if (wcnt >= lat) begin
          wcnt = 0;
          bus_ack = 1;
          if (bus_we) begin
            if (n_wr < 16) begin log_a[n_wr] = bus_addr; log_d[n_wr] = bus_wdata; end
            n_wr++;
          end else begin
            if (bus_addr != base_addr + 24'hCC) bad_rd++;
            bus_rdata = stat[(n_rd < n_stat) ? n_rd : n_stat - 1];
            n_rd++;
          end
        end else wcnt++;
      end
    end
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [BADDR_W-1:0] ea [0:15];
  logic [BUS_W-1:0]   ed [0:15];
  int ne;

  task automatic build_exp(logic [BADDR_W-1:0] b, logic [7:0] c, logic [31:0] a,
                           logic [31:0] l, logic [15:0] d, logic dv);
    ne = 0;
    ea[ne] = b + 24'h80; ed[ne] = {8'h00, c};  ne++;
    ea[ne] = b + 24'h88; ed[ne] = a[15:0];     ne++;
    ea[ne] = b + 24'h8A; ed[ne] = a[31:16];    ne++;
    if (l != 0) begin
      ea[ne] = b + 24'h90; ed[ne] = l[15:0];   ne++;
      ea[ne] = b + 24'h92; ed[ne] = l[31:16];  ne++;
    end
    if (dv) begin ea[ne] = b + 24'h84; ed[ne] = d; ne++; end
    ea[ne] = b + 24'hC0; ed[ne] = 16'h0001;    ne++;
  endtask

  task automatic issue(logic [BADDR_W-1:0] b, logic [7:0] c, logic [31:0] a,
                       logic [31:0] l, logic [15:0] d, logic dv);
    @(negedge clk);
    n_wr = 0; n_rd = 0; bad_rd = 0; wcnt = 0;
    base_addr = b; req_code = c; req_addr = a; req_len = l;
    req_data = d; req_data_vld = dv; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R9 ready low after accept", req_ready, 0);
    build_exp(b, c, a, l, d, dv);
  endtask

  task automatic wait_rsp(string tag);
    int n = 0;
    while (!rsp_valid && n < 400) begin @(negedge clk); n++; end
    chk({tag, " R7 response seen"}, rsp_valid, 1);
    @(negedge clk);
    chk({tag, " R7 single-cycle pulse"}, rsp_valid, 0);
    chk({tag, " R9 ready after response"}, req_ready, 1);
  endtask

  task automatic cmp_writes(string tag);
    chk({tag, " write count R3 R4"}, n_wr, ne);
    for (int i = 0; i < ne && i < n_wr; i++) begin
      chk($sformatf("%s R2 R3 R4 R5 write %0d addr", tag, i), log_a[i], ea[i]);
      chk($sformatf("%s R2 R3 R4 R5 write %0d data", tag, i), log_d[i], ed[i]);
    end
    chk({tag, " R7 poll address"}, bad_rd, 0);
  endtask

  task automatic t_reset();
    chk("R1 req_ready", req_ready, 1);
    chk("R1 bus_req", bus_req, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
  endtask

  task automatic t_minimal();
    lat = 0; stat[0] = 16'h0080; n_stat = 1;
    issue(24'h123400, 8'h41, 32'hDEAD_BEEF, 0, 16'h0, 0);
    wait_rsp("min");
    cmp_writes("min");
    chk("min R7 reads", n_rd, 1);
    chk("min R8 err", rsp_err, 0);
    chk("min R8 fail", rsp_fail, 0);
    chk("min R10 timeout", rsp_timeout, 0);
  endtask

  task automatic t_full();
    lat = 2; stat[0] = 0; stat[1] = 0; stat[2] = 16'h0080; n_stat = 3;
    issue(24'h000F00, 8'hE9, 32'h0102_0304, 32'h0005_0006, 16'hA5C3, 1);
    wait_rsp("full");
    cmp_writes("full R6");
    chk("full R7 reads until ready", n_rd, 3);
    chk("full R8 fail", rsp_fail, 0);
  endtask

  task automatic t_len_hi_only();
    lat = 1; stat[0] = 16'h0080; n_stat = 1;
    issue(24'h400000, 8'h20, 32'h0000_0010, 32'h0001_0000, 16'h1111, 0);
    wait_rsp("lenhi");
    cmp_writes("lenhi R3");
  endtask

  task automatic t_errors();
    lat = 0; stat[0] = 16'h00B0; n_stat = 1;
    issue(24'h000100, 8'h61, 32'h0, 0, 16'h7777, 1);
    wait_rsp("err1");
    cmp_writes("err1 R4");
    chk("err1 R8 err", rsp_err, 16'h0030);
    chk("err1 R8 fail", rsp_fail, 1);
    stat[0] = 16'hFFFF;
    issue(24'h000100, 8'h62, 32'h8000_0001, 0, 16'h0, 0);
    wait_rsp("err2");
    chk("err2 R8 err", rsp_err, 16'h133A);
    chk("err2 R8 fail", rsp_fail, 1);
    chk("err2 R10 timeout", rsp_timeout, 0);
  endtask

  task automatic t_timeout();
    lat = 1; stat[0] = 16'h0010; n_stat = 1;
    issue(24'h000200, 8'h98, 32'h0000_0020, 0, 16'h0, 0);
    wait_rsp("tmo");
    chk("tmo R10 reads", n_rd, MAXP);
    chk("tmo R10 timeout", rsp_timeout, 1);
    chk("tmo R10 err from last read", rsp_err, 16'h0010);
    repeat (10) @(negedge clk);
    chk("tmo R10 no further reads", n_rd, MAXP);
    chk("tmo R7 bus idle", bus_req, 0);
  endtask

  task automatic t_last_poll_ready();
    lat = 0; stat[0] = 0; stat[1] = 0; stat[2] = 0; stat[3] = 16'h0080; n_stat = 4;
    issue(24'h000300, 8'h97, 32'h0000_0030, 0, 16'h0, 0);
    wait_rsp("edge");
    chk("edge R10 reads", n_rd, MAXP);
    chk("edge R10 timeout clear", rsp_timeout, 0);
  endtask

  task automatic t_busy_ignore();
    lat = 2; stat[0] = 16'h0080; n_stat = 1;
    issue(24'h000500, 8'h41, 32'h0000_0040, 0, 16'h0, 0);
    repeat (3) @(negedge clk);
    req_code = 8'hC0; req_addr = 32'hFFFF_FFFF; req_valid = 1;
    repeat (2) @(negedge clk);
    req_valid = 0;
    wait_rsp("busy");
    cmp_writes("busy R9");
    repeat (10) @(negedge clk);
    chk("busy R9 no new sequence", n_wr, ne);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_minimal();
    t_full();
    t_len_hi_only();
    t_errors();
    t_timeout();
    t_last_poll_ready();
    t_busy_ignore();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule